// File: doc/BRIEF.md
# HDLC Data-Link Transmitter with Two-Half Word Buffer

This block turns octets written by a processor into HDLC frames and hands them out one bit at a time to the data-link bit positions of a framed line. The line framer pulses `bit_req` for each data-link slot. The block answers with the bit for that slot on `tx_bit`, which changes on the clock edge that samples the strobe and then holds. Between frames the block sends flag octets. Inside a frame it inserts a zero after every run of five ones, and it closes each frame with a 16-bit frame check sequence.

The processor writes 16-bit words into an eight-octet buffer. The buffer has four words, split into two halves of two words each. While one half is being sent, software refills the other half. The processor controls the block through a five-bit command write: start a frame, close it with the check sequence, abort it, hold the link in the all-ones state, and clear the sticky status. The block raises an interrupt when a half has been drained, when a frame has closed, and when the next half was not ready in time.

Top module: `hdlc_dl_tx`

## Requirements
- R1: After reset the link is disabled (`dl_stat[7]`=1) and `tx_bit` is 1. While command bit 3 (disable) is set, every slot carries 1 and start commands are ignored. Setting the bit mid-frame drops the frame. Clearing it restarts the idle flag from its first bit.
- R2: When enabled and idle, the slots carry the flag 0x7E, least significant bit first. `tx_bit` changes only on a clock edge where `bit_req` is high.
- R3: Command bit 0 (send) starts a frame at the next flag boundary. Octet 2w is the low byte of word w and octet 2w+1 is its high byte. Octets are sent in rising index order, each least significant bit first.
- R4: Within frame data and the check sequence, a 0 is inserted after every five consecutive ones. This includes a run that ends on the last check-sequence bit, before the closing flag.
- R5: Command bit 1 (close) makes the frame end at the end of the half being sent. The check sequence follows: the reflected CRC-16 (polynomial 0x8408), preset to 0xFFFF over the data bits, complemented, low byte first. Then flags resume and status bit 5 (frame done) is set.
- R6: Writing the second word of a half (word address bit 0 = 1) marks that half ready. When the last octet of a half has gone out, that half is released and status bit 4 (half done) is set. If no close command is pending, transmission continues in the other half.
- R7: If the other half is not ready when a half ends, or half 0 is not ready when a frame starts, status bit 6 (underrun) is set and the frame is aborted.
- R8: Command bit 2 (abort) during a frame replaces the frame with eight consecutive ones, followed by flags. Any abort releases both halves, so a new frame started without a refill underruns.
- R9: `irq` is high while any of status bits 4, 5 or 6 is set. Command bit 4 clears them, but an event in the same cycle wins over the clear.
- R10: `dl_stat[2:0]` is the octet pointer, which reads 4 after a four-octet frame. `dl_stat[3]` is high while a frame or abort is on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_req | input | 1 | One-cycle strobe asking for the next data-link bit |
| buf_we | input | 1 | Buffer word write enable |
| buf_waddr | input | 2 | Buffer word address (bit 1 selects the half) |
| buf_wdata | input | 16 | Buffer word data |
| ctl_we | input | 1 | Command write enable |
| ctl_wdata | input | 5 | Command bits: 0 send, 1 close, 2 abort, 3 disable, 4 clear status |
| tx_bit | output | 1 | Bit for the current data-link slot |
| irq | output | 1 | Interrupt, high while any event status is set |
| dl_stat | output | 8 | Pointer, busy, half done, frame done, underrun, disable |

## Verification
The assertions check properties that must hold on every cycle:
- the all-ones output while disabled;
- the held output between strobes;
- the bound of five on the run of ones inside a frame;
- that an underrun always lands in the abort state;
- that abort slots carry ones;
- that the CRC preset and ready marking follow their triggers.

Only the bench scenarios can show the frame as a whole. The bench passes the line stream through its own flag, destuffing and abort decoder, then compares octet order, the computed check sequence and the interrupt timing of the ping-pong refill against its expectations.

// File: rtl/hdlc_dl_pkg.sv
package hdlc_dl_pkg;
  localparam int OCT_W = 8;
  localparam int CRC_W = 16;
  localparam int CTL_W = 5;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;
  localparam logic [OCT_W-1:0] FLAG_OCT = 8'h7E;

  // command bit positions
  localparam int CMD_SEND  = 0;
  localparam int CMD_CLOSE = 1;
  localparam int CMD_ABORT = 2;
  localparam int CMD_DIS   = 3;
  localparam int CMD_CLR   = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_FCS, ST_ABORT} tx_state_e;

  // one data bit through the reflected CRC register
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_REFL : '0);
  endfunction
endpackage

// File: rtl/hdlc_dl_buf.sv
module hdlc_dl_buf
  import hdlc_dl_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int WORD_W = 16,
  localparam int WADDR_W = $clog2(NWORDS),
  localparam int PTR_W = $clog2(NWORDS * WORD_W / OCT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [PTR_W-1:0]   rd_ptr,
  input  logic               clr_en,
  input  logic               clr_idx,
  input  logic               clr_all,
  output logic [OCT_W-1:0]   rd_octet,
  output logic [1:0]         ready
);
  localparam int BSEL_W = PTR_W - WADDR_W;

  logic [WORD_W-1:0] mem_q [NWORDS];
  logic [WADDR_W-1:0] rd_word;
  logic last_word_wr;

  assign rd_word = rd_ptr[PTR_W-1 -: WADDR_W];
  assign last_word_wr = we && (&waddr[WADDR_W-2:0]);

  generate
    if (BSEL_W > 0) begin : g_sel
      assign rd_octet = mem_q[rd_word][rd_ptr[BSEL_W-1:0]*OCT_W +: OCT_W];
    end else begin : g_nosel
      assign rd_octet = mem_q[rd_word][OCT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      always_ff @(posedge clk) begin
        if (!rst_n) ready[h] <= 1'b0;
        else if (last_word_wr && waddr[WADDR_W-1] == 1'(h)) ready[h] <= 1'b1;
        else if (clr_all || (clr_en && clr_idx == 1'(h))) ready[h] <= 1'b0;
      end
    end
  endgenerate

  a_r6_ready_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    last_word_wr |=> ready[$past(waddr[WADDR_W-1])]);
endmodule

// File: rtl/hdlc_dl_crc.sv
module hdlc_dl_crc
  import hdlc_dl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step_en,
  input  logic             step_bit,
  input  logic             shift_en,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= CRC_PRESET;
    else if (step_en) crc_q <= crc_step(crc_q, step_bit);
    else if (shift_en) crc_q <= {1'b1, crc_q[CRC_W-1:1]};
  end

  a_r5_preset: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> crc_q == CRC_PRESET);
endmodule

// File: rtl/hdlc_dl_tx.sv
module hdlc_dl_tx
  import hdlc_dl_pkg::*;
#(
  parameter int BUF_WORDS = 4,
  parameter int WORD_W = 16,
  localparam int WADDR_W = $clog2(BUF_WORDS),
  localparam int PTR_W = $clog2(BUF_WORDS * WORD_W / OCT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_req,
  input  logic               buf_we,
  input  logic [WADDR_W-1:0] buf_waddr,
  input  logic [WORD_W-1:0]  buf_wdata,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic               tx_bit,
  output logic               irq,
  output logic [PTR_W+4:0]   dl_stat
);
  localparam logic [3:0] OCT_LAST = 4'd7;
  localparam logic [3:0] FCS_LAST = 4'(CRC_W - 1);

  tx_state_e state_q;
  logic [3:0] cnt_q;
  logic [2:0] ones_q;
  logic [PTR_W-1:0] ptr_q;
  logic dis_q, start_pend_q, close_pend_q, abort_pend_q;
  logic st_half_q, st_frame_q, st_unr_q, tx_q;

  logic [OCT_W-1:0] octet;
  logic [1:0] ready;
  logic [CRC_W-1:0] crc;

  // named internal events
  logic in_frame, abort_now, stuff, cand, out_bit, adv, last;
  logic half_end, frame_start, underrun_ev, abort_ev, fcs_end;
  logic cur_half, nxt_half;

  assign in_frame   = (state_q == ST_DATA) || (state_q == ST_FCS);
  assign abort_now  = abort_pend_q && in_frame;
  assign stuff      = (ones_q == 3'd5) && !abort_now;
  assign cur_half   = ptr_q[PTR_W-1];
  assign nxt_half   = ~cur_half;

  always_comb begin
    case (state_q)
      ST_IDLE: cand = FLAG_OCT[cnt_q[2:0]];
      ST_DATA: cand = octet[cnt_q[2:0]];
      ST_FCS:  cand = ~crc[0];
      default: cand = 1'b1;
    endcase
  end

  assign out_bit     = (dis_q || abort_now) ? 1'b1 : (stuff ? 1'b0 : cand);
  assign adv         = bit_req && !dis_q && !stuff && !abort_now;
  assign last        = (state_q == ST_FCS) ? (cnt_q == FCS_LAST) : (cnt_q[2:0] == OCT_LAST[2:0]);
  assign half_end    = (state_q == ST_DATA) && adv && last && (&ptr_q[PTR_W-2:0]);
  assign frame_start = (state_q == ST_IDLE) && adv && last && start_pend_q;
  assign fcs_end     = (state_q == ST_FCS) && adv && last;
  assign underrun_ev = (half_end && !close_pend_q && !ready[nxt_half]) ||
                       (frame_start && !ready[0]);
  assign abort_ev    = (bit_req && abort_now && !dis_q) || underrun_ev;

  hdlc_dl_buf #(.NWORDS(BUF_WORDS), .WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .rd_ptr(ptr_q), .clr_en(half_end), .clr_idx(cur_half), .clr_all(abort_ev),
    .rd_octet(octet), .ready(ready)
  );

  hdlc_dl_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(frame_start),
    .step_en((state_q == ST_DATA) && adv), .step_bit(cand),
    .shift_en((state_q == ST_FCS) && adv), .crc_q(crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; ones_q <= '0; ptr_q <= '0;
      dis_q <= 1'b1; start_pend_q <= 1'b0; close_pend_q <= 1'b0; abort_pend_q <= 1'b0;
      st_half_q <= 1'b0; st_frame_q <= 1'b0; st_unr_q <= 1'b0; tx_q <= 1'b1;
    end else begin
      if (bit_req) tx_q <= out_bit;
      if (dis_q) begin
        state_q <= ST_IDLE; cnt_q <= '0; ones_q <= '0;
        start_pend_q <= 1'b0; close_pend_q <= 1'b0; abort_pend_q <= 1'b0;
      end else if (bit_req) begin
        if (abort_now) begin
          state_q <= ST_ABORT; cnt_q <= 4'd1; ones_q <= '0;
          abort_pend_q <= 1'b0; close_pend_q <= 1'b0;
        end else if (stuff) begin
          ones_q <= '0;
        end else begin
          cnt_q <= last ? '0 : 4'(cnt_q + 4'd1);
          ones_q <= (in_frame && cand) ? 3'(ones_q + 3'd1) : '0;
          case (state_q)
            ST_IDLE: if (last && start_pend_q) begin
              start_pend_q <= 1'b0; ptr_q <= '0;
              if (ready[0]) state_q <= ST_DATA;
              else begin state_q <= ST_ABORT; ones_q <= '0; end
            end
            ST_DATA: if (last) begin
              ptr_q <= PTR_W'(ptr_q + 1'b1);
              if (&ptr_q[PTR_W-2:0]) begin
                if (close_pend_q) begin state_q <= ST_FCS; close_pend_q <= 1'b0; end
                else if (!ready[nxt_half]) begin state_q <= ST_ABORT; ones_q <= '0; end
              end
            end
            default: if (last) state_q <= ST_IDLE;
          endcase
        end
      end
      if (ctl_we) begin
        dis_q <= ctl_wdata[CMD_DIS];
        if (ctl_wdata[CMD_DIS]) begin
          start_pend_q <= 1'b0; close_pend_q <= 1'b0; abort_pend_q <= 1'b0;
        end else begin
          if (ctl_wdata[CMD_SEND] && state_q == ST_IDLE && !dis_q) start_pend_q <= 1'b1;
          if (ctl_wdata[CMD_CLOSE]) close_pend_q <= 1'b1;
          if (ctl_wdata[CMD_ABORT]) begin
            start_pend_q <= 1'b0;
            if (in_frame) abort_pend_q <= 1'b1;
          end
        end
        if (ctl_wdata[CMD_CLR]) begin
          st_half_q <= 1'b0; st_frame_q <= 1'b0; st_unr_q <= 1'b0;
        end
      end
      if (half_end) st_half_q <= 1'b1;
      if (fcs_end) st_frame_q <= 1'b1;
      if (underrun_ev) st_unr_q <= 1'b1;
    end
  end

  assign tx_bit  = tx_q;
  assign irq     = st_half_q | st_frame_q | st_unr_q;
  assign dl_stat = {dis_q, st_unr_q, st_frame_q, st_half_q, (state_q != ST_IDLE), ptr_q};

  a_r1_disabled_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && dis_q) |=> tx_bit);
  a_r2_hold_between_slots: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_req |=> $stable(tx_bit));
  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> ones_q <= 3'd5);
  a_r7_underrun_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_unr_q) |-> (state_q == ST_ABORT));
  a_r8_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT && bit_req) |=> tx_bit);
  a_r5_fcs_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_FCS) |-> $past(state_q) == ST_DATA);
endmodule

// File: tb/hdlc_dl_tx_bench.sv
module hdlc_dl_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bit_req = 1'b0;
  logic buf_we = 1'b0, ctl_we = 1'b0;
  logic [1:0] buf_waddr = '0;
  logic [15:0] buf_wdata = '0;
  logic [4:0] ctl_wdata = '0;
  logic tx_bit, irq;
  logic [7:0] dl_stat;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // line decoder state
  int rx_ones = 0, rx_nb = 0, rx_frames = 0, rx_aborts = 0, rx_len = 0;
  bit rx_in = 0;
  logic rx_bits [0:511];
  logic [7:0] rx_oct [0:31];
  logic [7:0] dat [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_dl_tx u_hdlc_dl_tx (
    .clk(clk), .rst_n(rst_n), .bit_req(bit_req), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tx_bit(tx_bit), .irq(irq), .dl_stat(dl_stat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rx_feed(input logic b);
    if (b) begin
      rx_ones++;
      if (rx_ones == 7) begin rx_aborts++; rx_in = 0; rx_nb = 0; end
      else if (rx_in && rx_nb < 512) begin rx_bits[rx_nb] = 1'b1; rx_nb++; end
    end else begin
      if (rx_ones == 5) begin
        rx_ones = 0;
      end else if (rx_ones == 6) begin
        if (rx_in && rx_nb > 7) begin
          rx_frames++;
          rx_len = (rx_nb - 7) / 8;
          for (int k = 0; k < rx_len && k < 32; k++)
            for (int i = 0; i < 8; i++) rx_oct[k][i] = rx_bits[8*k+i];
        end
        rx_in = 1; rx_nb = 0; rx_ones = 0;
      end else begin
        rx_ones = 0;
        if (rx_in && rx_nb < 512) begin rx_bits[rx_nb] = 1'b0; rx_nb++; end
      end
    end
  endtask

  task automatic step(output logic b);
    @(negedge clk) bit_req = 1'b1;
    @(negedge clk) bit_req = 1'b0;
    b = tx_bit;
    rx_feed(b);
  endtask

  task automatic run(input int n);
    logic b;
    for (int i = 0; i < n; i++) step(b);
  endtask

  task automatic ctl(input logic [4:0] v);
    @(negedge clk) ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk) ctl_we = 1'b0;
  endtask

  task automatic wr_word(input int w, input int oct_base);
    @(negedge clk) buf_we = 1'b1; buf_waddr = 2'(w);
    buf_wdata = {dat[oct_base+1], dat[oct_base]};
    @(negedge clk) buf_we = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    logic b;
    int k;
    k = 0;
    while (!irq && k < 600) begin step(b); k++; end
    chk(irq == 1'b1, req, int'(irq), 1);
  endtask

  function automatic logic [15:0] bench_fcs(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {8'h00, dat[k]};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic chk_frame(input int n, input string req);
    logic [15:0] f;
    int bad;
    f = bench_fcs(n);
    chk(rx_len == n + 2, {req, " length"}, rx_len, n + 2);
    bad = 0;
    for (int k = 0; k < n; k++) if (rx_oct[k] !== dat[k]) bad++;
    chk(bad == 0, {req, " data octets"}, bad, 0);
    chk(rx_oct[n] == f[7:0] && rx_oct[n+1] == f[15:8], "R5 check sequence",
        int'({rx_oct[n+1], rx_oct[n]}), int'(f));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic b;
    int zeros, bad, fr0, ab0;
    logic [7:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R10: reset state
    chk(tx_bit == 1'b1, "R1 reset tx", int'(tx_bit), 1);
    chk(dl_stat == 8'h80 && !irq, "R10 reset status", int'(dl_stat), 8'h80);

    // R1: disabled send ignored, all ones
    ctl(5'b01001);
    zeros = 0;
    for (int i = 0; i < 24; i++) begin step(b); if (!b) zeros++; end
    chk(zeros == 0, "R1 disabled ones", zeros, 0);
    chk(dl_stat[3] == 1'b0, "R1 send ignored", int'(dl_stat[3]), 0);

    // R2: idle flags
    ctl(5'b00000);
    bad = 0;
    for (int i = 0; i < 16; i++) begin step(b); if (b !== pat_bit(i)) bad++; end
    chk(bad == 0, "R2 idle flag pattern", bad, 0);
    pat[0] = tx_bit;
    repeat (4) @(negedge clk);
    chk(tx_bit == pat[0], "R2 hold without strobe", int'(tx_bit), int'(pat[0]));

    // R3 R4 R5: four-octet frame with stuffing-heavy data
    dat[0] = 8'h7E; dat[1] = 8'hFF; dat[2] = 8'h3C; dat[3] = 8'hF8;
    wr_word(0, 0); wr_word(1, 2);
    fr0 = rx_frames; ab0 = rx_aborts;
    ctl(5'b00011);
    run(120);
    chk(rx_frames == fr0 + 1, "R3 one frame", rx_frames, fr0 + 1);
    chk(rx_aborts == ab0, "R4 stuffing keeps runs short", rx_aborts, ab0);
    chk_frame(4, "R3");
    chk(dl_stat[6:3] == 4'b0110, "R6 R5 status after frame", int'(dl_stat[6:3]), 6);
    chk(dl_stat[2:0] == 3'd4, "R10 pointer", int'(dl_stat[2:0]), 4);
    chk(irq == 1'b1, "R9 irq set", int'(irq), 1);
    ctl(5'b10000);
    chk(irq == 1'b0 && dl_stat[6:4] == 3'b000, "R9 clear", int'(dl_stat[6:4]), 0);

    // R6: ping-pong twelve-octet frame
    for (int k = 0; k < 12; k++) dat[k] = 8'((k * 37 + 5) ^ (k << 5));
    dat[5] = 8'hFF;
    wr_word(0, 0); wr_word(1, 2); wr_word(2, 4); wr_word(3, 6);
    fr0 = rx_frames; ab0 = rx_aborts;
    ctl(5'b00001);
    wait_irq("R6 first half drained");
    ctl(5'b10000);
    wr_word(0, 8); wr_word(1, 10);
    wait_irq("R6 second half drained");
    ctl(5'b10010);
    run(160);
    chk(rx_frames == fr0 + 1 && rx_aborts == ab0, "R6 refilled frame closes", rx_frames, fr0 + 1);
    chk_frame(12, "R6");

    // R7: underrun
    ctl(5'b10000);
    wr_word(0, 0); wr_word(1, 2);
    fr0 = rx_frames; ab0 = rx_aborts;
    ctl(5'b00001);
    run(150);
    chk(dl_stat[6] == 1'b1 && irq, "R7 underrun status", int'(dl_stat[6]), 1);
    chk(rx_aborts == ab0 + 1 && rx_frames == fr0, "R7 underrun aborts", rx_aborts, ab0 + 1);

    // R8: abort command, then buffer discarded
    ctl(5'b10000);
    wr_word(0, 0); wr_word(1, 2); wr_word(2, 4); wr_word(3, 6);
    fr0 = rx_frames; ab0 = rx_aborts;
    ctl(5'b00001);
    run(30);
    ctl(5'b00100);
    run(40);
    chk(rx_aborts == ab0 + 1 && rx_frames == fr0, "R8 abort on line", rx_aborts, ab0 + 1);
    chk(dl_stat[6] == 1'b0 && dl_stat[3] == 1'b0, "R8 no underrun, idle", int'(dl_stat[6:3]), 0);
    ctl(5'b00011);
    run(40);
    chk(dl_stat[6] == 1'b1, "R8 halves released", int'(dl_stat[6]), 1);

    // R1: disable mid-frame, then flag restarts
    ctl(5'b10000);
    wr_word(0, 0); wr_word(1, 2);
    ctl(5'b00011);
    run(20);
    ctl(5'b01000);
    zeros = 0;
    for (int i = 0; i < 20; i++) begin step(b); if (!b) zeros++; end
    chk(zeros == 0, "R1 disable mid-frame", zeros, 0);
    chk(dl_stat[3] == 1'b0, "R1 frame dropped", int'(dl_stat[3]), 0);
    ctl(5'b00000);
    bad = 0;
    for (int i = 0; i < 8; i++) begin step(b); if (b !== pat_bit(i)) bad++; end
    chk(bad == 0, "R1 R2 flag restarts", bad, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic pat_bit(input int i);
    logic [7:0] f;
    f = 8'h7E;
    return f[i % 8];
  endfunction
endmodule